// File: doc/BRIEF.md
# ATA PIO Register Cycle Sequencer

This block is the host side of a parallel ATA port for single 8-bit register accesses. A client presents one request (read or write, a 5-bit register address, write data and a speed-mode select). The block then runs one complete programmed-I/O register cycle on the port pins. It drives the two active-low chip selects, the three address lines, the active-low read and write strobes and the data-bus output enable. When the cycle is over it returns the read data together with a one-cycle done pulse.

Every phase of the cycle is counted in system clocks. All counts are derived at elaboration from the clock period and the nanosecond limits of the slow mode (mode 0) and the fast mode (mode 4), rounded up to whole clocks. The strobe phase is lengthened so that the complete cycle always reaches the minimum cycle time of the mode. A device can also stretch the strobe by holding the ready line low. The ready line passes through a synchronizer and is inspected at a fixed delay after the strobe asserts. A ready line held low beyond the legal maximum ends the cycle with an error flag, so the port never hangs.

Top module: `ata_pio_seq`

## Requirements
- R1: While a cycle runs, `cs_n[1]` = NOT `req_addr[4]`, `cs_n[0]` = NOT `req_addr[3]` and `da` = `req_addr[2:0]`, all latched at acceptance and stable for the whole cycle. When idle, `cs_n` = 2'b11, `da` = 0, both strobes are high and `dd_oe` is low.
- R2: The address phase ahead of the strobe lasts ceil(t1/Tclk) clocks: 4 in mode 0 (70 ns) and 2 in mode 4 (25 ns) at 20 ns.
- R3: The strobe (`diow_n` for writes, `dior_n` for reads) stays low for max(ceil(t2/Tclk), ceil(t0/Tclk) - setup - recovery, tA clocks + 1). That is 24 clocks in mode 0 and 4 clocks in mode 4 when no wait occurs. Only the strobe that matches the direction ever goes low.
- R4: After the strobe negates, the address stays driven for a recovery phase of max(t2i, t9, t4) rounded up, with at least one clock (2 clocks in both modes at 20 ns). The whole cycle is never shorter than the mode's minimum cycle time (30 or 6 clocks).
- R5: On a write, `dd_oe` is high in every clock of the cycle and `dd_out` equals the write data. On a read, `dd_oe` stays low.
- R6: On a read, `rdata` holds the `dd_in` value sampled at the last clock edge before `dior_n` negates. It is valid while `done` is high.
- R7: If the synchronized ready line is low tA clocks into the strobe, the strobe stays asserted until the synchronized line is high again, and the cycle then completes with `err` = 0.
- R8: If the ready line stays low for more than ceil(1250 ns/Tclk) clocks of waiting, the strobe is released, the cycle finishes normally and `done` pulses with `err` = 1.
- R9: `done` is a single-clock pulse at the end of each cycle. `busy` is high from acceptance until that pulse. A `req_valid` seen while busy is ignored, so no second cycle is started.
- R10: `req_mode` (0 = mode 0, 1 = mode 4) is latched when the request is accepted. Changing it during a cycle does not alter that cycle's timing.
- R11: After reset the port is idle as in R1, with `busy`, `done` and `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a cycle (taken when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | {sel CS1, sel CS0, DA[2:0]} |
| req_wdata | input | 8 | Write data |
| req_mode | input | 1 | 0 = PIO mode 0, 1 = PIO mode 4 |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Ready timeout, valid with done |
| rdata | output | 8 | Read data, valid with done |
| cs_n | output | 2 | Chip selects, active low |
| da | output | 3 | Register address lines |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 8 | Data bus drive value |
| dd_oe | output | 1 | Data bus output enable |
| dd_in | input | 8 | Data bus sampled value |
| iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
The bench builds the block with its default parameters: a 20 ns clock period, the standard nanosecond limits for both modes, a 1250 ns ready limit and a two-stage synchronizer. With these values the strobe of mode 0 is set by the cycle-time floor and not by the pulse-width minimum, while mode 4 is set by the width. Both branches of the strobe-length maximum are therefore exercised. The 63-clock ready timeout is short enough to run to expiry, so a stretched strobe and an aborted strobe can both be measured against a nominal one.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_RECOV  = 2'd3
    } seq_state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing #(
    parameter int CLK_NS  = 20,
    parameter int CW      = 8,
    parameter int TA_NS   = 35,
    parameter int M0_T0   = 600,
    parameter int M0_T1   = 70,
    parameter int M0_T2   = 290,
    parameter int M0_T2I  = 0,
    parameter int M0_T4   = 30,
    parameter int M0_T9   = 20,
    parameter int M4_T0   = 120,
    parameter int M4_T1   = 25,
    parameter int M4_T2   = 70,
    parameter int M4_T2I  = 25,
    parameter int M4_T4   = 10,
    parameter int M4_T9   = 10
) (
    input  logic          mode,
    output logic [CW-1:0] su_cyc,
    output logic [CW-1:0] sw_cyc,
    output logic [CW-1:0] rec_cyc,
    output logic [CW-1:0] ta_cyc
);
    import ata_pio_pkg::*;

    localparam int TA = imax(ceil_div(TA_NS, CLK_NS), 1);

    localparam int SU0  = imax(ceil_div(M0_T1, CLK_NS), 1);
    localparam int REC0 = imax(imax(ceil_div(M0_T2I, CLK_NS), ceil_div(M0_T9, CLK_NS)),
                               imax(ceil_div(M0_T4, CLK_NS), 1));
    localparam int SW0  = imax(imax(ceil_div(M0_T2, CLK_NS), ceil_div(M0_T0, CLK_NS) - SU0 - REC0),
                               TA + 1);

    localparam int SU4  = imax(ceil_div(M4_T1, CLK_NS), 1);
    localparam int REC4 = imax(imax(ceil_div(M4_T2I, CLK_NS), ceil_div(M4_T9, CLK_NS)),
                               imax(ceil_div(M4_T4, CLK_NS), 1));
    localparam int SW4  = imax(imax(ceil_div(M4_T2, CLK_NS), ceil_div(M4_T0, CLK_NS) - SU4 - REC4),
                               TA + 1);

    always_comb begin
        ta_cyc = CW'(TA);
        if (mode) begin
            su_cyc  = CW'(SU4);
            sw_cyc  = CW'(SW4);
            rec_cyc = CW'(REC4);
        end else begin
            su_cyc  = CW'(SU0);
            sw_cyc  = CW'(SW0);
            rec_cyc = CW'(REC0);
        end
    end

endmodule

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm #(
    parameter int CW     = 8,
    parameter int TB_CYC = 63
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [4:0]    req_addr,
    input  logic [7:0]    req_wdata,
    input  logic          req_mode,
    input  logic          rdy_s,
    input  logic [7:0]    dd_in,
    input  logic [CW-1:0] su_cyc,
    input  logic [CW-1:0] sw_cyc,
    input  logic [CW-1:0] rec_cyc,
    input  logic [CW-1:0] ta_cyc,
    output logic          mode_lat,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [7:0]    rdata,
    output logic [1:0]    cs_n,
    output logic [2:0]    da,
    output logic          dior_n,
    output logic          diow_n,
    output logic [7:0]    dd_out,
    output logic          dd_oe
);
    import ata_pio_pkg::*;

    typedef struct packed {
        seq_state_t  st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] wcnt;
        logic        waiting;
        logic        wr;
        logic        mode;
        logic [4:0]  addr;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        logic        done;
        logic        err;
        logic        busy;
        logic [1:0]  cs_n;
        logic [2:0]  da;
        logic        dior_n;
        logic        diow_n;
        logic        oe;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ST_IDLE, cnt: '0, wcnt: '0, waiting: 1'b0, wr: 1'b0, mode: 1'b0,
        addr: '0, wdata: '0, rdata: '0, done: 1'b0, err: 1'b0, busy: 1'b0,
        cs_n: 2'b11, da: '0, dior_n: 1'b1, diow_n: 1'b1, oe: 1'b0
    };

    seq_regs_t r_d, r_q;

    logic at_sample;
    logic rdy_low_now;
    logic timed_out;
    logic width_met;

    always_comb begin
        at_sample   = (r_q.cnt == ta_cyc - CW'(1));
        rdy_low_now = at_sample && !rdy_s;
        timed_out   = r_q.waiting && !rdy_s && (r_q.wcnt >= CW'(TB_CYC - 1));
        width_met   = (r_q.cnt >= sw_cyc - CW'(1));
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_SETUP;
                    r_d.cnt   = '0;
                    r_d.wr    = req_write;
                    r_d.mode  = req_mode;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.busy  = 1'b1;
                    r_d.err   = 1'b0;
                end
            end
            ST_SETUP: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt >= su_cyc - CW'(1)) begin
                    r_d.st      = ST_STROBE;
                    r_d.cnt     = '0;
                    r_d.wcnt    = '0;
                    r_d.waiting = 1'b0;
                end
            end
            ST_STROBE: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (rdy_low_now) begin
                    r_d.waiting = 1'b1;
                end
                if (r_q.waiting) begin
                    if (rdy_s) r_d.waiting = 1'b0;
                    else       r_d.wcnt    = r_q.wcnt + CW'(1);
                end
                if (timed_out || (width_met && !r_q.waiting && !rdy_low_now)) begin
                    r_d.st      = ST_RECOV;
                    r_d.cnt     = '0;
                    r_d.waiting = 1'b0;
                    r_d.err     = timed_out;
                    if (!r_q.wr) r_d.rdata = dd_in;
                end
            end
            ST_RECOV: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt >= rec_cyc - CW'(1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.busy = 1'b0;
                end
            end
            default: r_d = RESET_VAL;
        endcase

        // Registered pin values follow the next state
        if (r_d.st == ST_IDLE) begin
            r_d.cs_n = 2'b11;
            r_d.da   = '0;
            r_d.oe   = 1'b0;
        end else begin
            r_d.cs_n = ~r_d.addr[4:3];
            r_d.da   = r_d.addr[2:0];
            r_d.oe   = r_d.wr;
        end
        r_d.dior_n = !((r_d.st == ST_STROBE) && !r_d.wr);
        r_d.diow_n = !((r_d.st == ST_STROBE) &&  r_d.wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign mode_lat = r_q.mode;
    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign rdata    = r_q.rdata;
    assign cs_n     = r_q.cs_n;
    assign da       = r_q.da;
    assign dior_n   = r_q.dior_n;
    assign diow_n   = r_q.diow_n;
    assign dd_out   = r_q.wdata;
    assign dd_oe    = r_q.oe;

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq #(
    parameter int CLK_NS      = 20,
    parameter int SYNC_STAGES = 2,
    parameter int TA_NS       = 35,
    parameter int TB_NS       = 1250,
    parameter int M0_T0       = 600,
    parameter int M0_T1       = 70,
    parameter int M0_T2       = 290,
    parameter int M0_T2I      = 0,
    parameter int M0_T4       = 30,
    parameter int M0_T9       = 20,
    parameter int M4_T0       = 120,
    parameter int M4_T1       = 25,
    parameter int M4_T2       = 70,
    parameter int M4_T2I      = 25,
    parameter int M4_T4       = 10,
    parameter int M4_T9       = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [4:0] req_addr,
    input  logic [7:0] req_wdata,
    input  logic       req_mode,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [7:0] rdata,
    output logic [1:0] cs_n,
    output logic [2:0] da,
    output logic       dior_n,
    output logic       diow_n,
    output logic [7:0] dd_out,
    output logic       dd_oe,
    input  logic [7:0] dd_in,
    input  logic       iordy
);
    import ata_pio_pkg::*;

    localparam int TB_CYC = ceil_div(TB_NS, CLK_NS);
    localparam int SPAN   = TB_CYC + ceil_div(M0_T0, CLK_NS) + ceil_div(TA_NS, CLK_NS) + 16;
    localparam int CW     = $clog2(SPAN);

    logic          rdy_s;
    logic          mode_lat;
    logic [CW-1:0] su_cyc, sw_cyc, rec_cyc, ta_cyc;

    ata_pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (iordy),
        .dout (rdy_s)
    );

    ata_pio_timing #(
        .CLK_NS(CLK_NS), .CW(CW), .TA_NS(TA_NS),
        .M0_T0(M0_T0), .M0_T1(M0_T1), .M0_T2(M0_T2), .M0_T2I(M0_T2I), .M0_T4(M0_T4), .M0_T9(M0_T9),
        .M4_T0(M4_T0), .M4_T1(M4_T1), .M4_T2(M4_T2), .M4_T2I(M4_T2I), .M4_T4(M4_T4), .M4_T9(M4_T9)
    ) u_timing (
        .mode   (mode_lat),
        .su_cyc (su_cyc),
        .sw_cyc (sw_cyc),
        .rec_cyc(rec_cyc),
        .ta_cyc (ta_cyc)
    );

    ata_pio_fsm #(.CW(CW), .TB_CYC(TB_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_mode (req_mode),
        .rdy_s    (rdy_s),
        .dd_in    (dd_in),
        .su_cyc   (su_cyc),
        .sw_cyc   (sw_cyc),
        .rec_cyc  (rec_cyc),
        .ta_cyc   (ta_cyc),
        .mode_lat (mode_lat),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rdata    (rdata),
        .cs_n     (cs_n),
        .da       (da),
        .dior_n   (dior_n),
        .diow_n   (diow_n),
        .dd_out   (dd_out),
        .dd_oe    (dd_oe)
    );

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cs_n,
    input logic [2:0] da,
    input logic       dior_n,
    input logic       diow_n,
    input logic [7:0] dd_out,
    input logic       dd_oe,
    input logic       done,
    input logic       busy
);
    logic cs_act;
    logic strb;
    assign cs_act = (cs_n != 2'b11);
    assign strb   = !dior_n || !diow_n;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n)); // R3

    AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> cs_act); // R1

    AST_ADDR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb) |-> $past(cs_act)); // R2

    AST_ADDR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb) |-> cs_act); // R4

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act)) |-> ($stable(cs_n) && $stable(da))); // R1

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe |-> dior_n); // R5

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dd_oe && $past(dd_oe)) |-> $stable(dd_out)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_BUSY_COVERS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_act |-> busy); // R9

endmodule

bind ata_pio_seq ata_pio_seq_chk u_chk (.*);

// File: tb/ata_pio_seq_tb.sv
`timescale 1ns/1ps
module ata_pio_seq_tb;

    typedef struct packed {
        logic       wr;
        logic [4:0] addr;
        logic [7:0] wd;
        logic [7:0] rd;
        logic       mode;
        int         su;
        int         sw;
        int         tot;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'b01110, 8'hA5, 8'h00, 1'b1, 2, 4, 8},
        '{1'b0, 5'b10110, 8'h00, 8'h3C, 1'b1, 2, 4, 8},
        '{1'b1, 5'b01001, 8'h5A, 8'h00, 1'b0, 4, 24, 30},
        '{1'b0, 5'b01111, 8'h00, 8'hC3, 1'b0, 4, 24, 30},
        '{1'b0, 5'b10000, 8'h00, 8'h81, 1'b1, 2, 4, 8}
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic       req_valid = 0, req_write = 0, req_mode = 0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0, dd_in = '0;
    logic       iordy = 1;
    logic       busy, done, err, dior_n, diow_n, dd_oe;
    logic [7:0] rdata, dd_out;
    logic [1:0] cs_n;
    logic [2:0] da;

    always #10 clk = ~clk;

    ata_pio_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mode(req_mode),
        .busy(busy), .done(done), .err(err), .rdata(rdata), .cs_n(cs_n), .da(da),
        .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe),
        .dd_in(dd_in), .iordy(iordy)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int m_su, m_sw, m_post, m_addr_bad, m_oe_bad, m_wrong_strb, m_busy_bad;
    logic [7:0] m_rdata;
    logic m_err, m_done;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One register cycle; rise_at = strobe clocks before IORDY goes high (-1: none),
    // flip_at / spur_at = loop step for mode toggle / stray request (-1: none)
    task automatic run_op(input logic wr, input logic [4:0] a, input logic [7:0] wd,
                          input logic [7:0] rd, input logic md,
                          input int rise_at, input int flip_at, input int spur_at);
        bit seen;
        logic sl, wl;
        seen = 0;
        m_su = 0; m_sw = 0; m_post = 0; m_addr_bad = 0; m_oe_bad = 0;
        m_wrong_strb = 0; m_busy_bad = 0; m_done = 0; m_err = 0; m_rdata = '0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_mode = md; dd_in = rd;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin
                m_done = 1; m_err = err; m_rdata = rdata;
                break;
            end
            if (req_valid) begin req_valid = 0; req_addr = a; end
            sl = wr ? !diow_n : !dior_n;
            wl = wr ? !dior_n : !diow_n;
            if (wl) m_wrong_strb++;
            if (!busy) m_busy_bad++;
            if (cs_n != ~a[4:3] || da != a[2:0]) m_addr_bad++;
            if (wr && (!dd_oe || dd_out != wd)) m_oe_bad++;
            if (!wr && dd_oe) m_oe_bad++;
            if (sl) begin m_sw++; seen = 1; end
            else if (!seen) m_su++;
            else m_post++;
            if (rise_at >= 0 && m_sw == rise_at) iordy = 1;
            if (i == flip_at) req_mode = ~md;
            if (i == spur_at) begin req_valid = 1; req_addr = ~a; end
            @(negedge clk);
        end
        req_valid = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(cs_n == 2'b11 && da == 3'd0, "R11 idle address", int'({cs_n, da}), 24);
        chk(dior_n && diow_n && !dd_oe, "R11 idle strobes", int'({dior_n, diow_n, dd_oe}), 6);
        chk(!busy && !done && !err, "R11 idle status", int'({busy, done, err}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v].wr, VEC[v].addr, VEC[v].wd, VEC[v].rd, VEC[v].mode, -1, -1, -1);
            chk(m_done == 1, "R9 done seen", m_done, 1);
            chk(m_addr_bad == 0, "R1 address lines", m_addr_bad, 0);
            chk(m_su == VEC[v].su, "R2 address setup", m_su, VEC[v].su);
            chk(m_sw == VEC[v].sw && m_wrong_strb == 0, "R3 strobe width", m_sw, VEC[v].sw);
            chk(m_post == 2, "R4 recovery hold", m_post, 2);
            chk(m_su + m_sw + m_post >= VEC[v].tot, "R4 cycle time", m_su + m_sw + m_post, VEC[v].tot);
            chk(m_oe_bad == 0, "R5 data drive", m_oe_bad, 0);
            if (!VEC[v].wr) chk(m_rdata == VEC[v].rd, "R6 read data", int'(m_rdata), int'(VEC[v].rd));
            chk(m_err == 0, "R8 no error", int'(m_err), 0);
            @(negedge clk);
            chk(!done && cs_n == 2'b11, "R9 done one clock", int'(done), 0);
        end

        // R7: device holds ready low, releases after 20 strobe clocks
        iordy = 0;
        run_op(1'b0, 5'b01010, 8'h00, 8'h6E, 1'b1, 20, -1, -1);
        chk(m_sw >= 21 && m_sw <= 26, "R7 stretched strobe", m_sw, 23);
        chk(m_done && !m_err && m_rdata == 8'h6E, "R7 completes", int'(m_rdata), 8'h6E);

        // R8: ready never returns
        iordy = 0;
        run_op(1'b1, 5'b10011, 8'h77, 8'h00, 1'b1, -1, -1, -1);
        iordy = 1;
        chk(m_done == 1 && m_err == 1, "R8 timeout error", int'(m_err), 1);
        chk(m_sw >= 63 && m_sw <= 70, "R8 timeout length", m_sw, 65);
        chk(m_post == 2, "R8 recovery after abort", m_post, 2);
        repeat (3) @(negedge clk);

        // R10: mode input flips mid-cycle
        run_op(1'b1, 5'b01100, 8'h99, 8'h00, 1'b1, -1, 1, -1);
        chk(m_sw == 4 && m_su == 2, "R10 mode latched", m_sw, 4);
        req_mode = 0;
        run_op(1'b0, 5'b10101, 8'h00, 8'h12, 1'b0, -1, 2, -1);
        chk(m_sw == 24, "R10 mode latched slow", m_sw, 24);

        // R9: stray request while busy
        run_op(1'b0, 5'b01011, 8'h00, 8'h4D, 1'b0, -1, -1, 5);
        chk(m_addr_bad == 0 && m_busy_bad == 0, "R9 stray ignored in cycle", m_addr_bad, 0);
        begin
            int act = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (cs_n != 2'b11 || busy) act++;
            end
            chk(act == 0, "R9 no second cycle", act, 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule